// File: doc/BRIEF.md
# Timer0 Unit with Shared Prescaler

This block is an 8-bit up-counter for a small microcontroller core. It counts either instruction cycles or edges on an external input pin. An 8-bit prescaler sits in front of it, and that prescaler is shared with the watchdog. One control bit hands the prescaler to the timer or to the watchdog. The unit that does not hold the prescaler sees its own events undivided.

The core clock runs at the oscillator rate. Two one-cycle strobes mark the second and the fourth quarter of each instruction cycle, and the fourth-quarter strobe also marks the end of the instruction cycle. The pin passes through a synchronizer and is sampled on both strobes. The counter only ever advances on a fourth-quarter strobe.

A write to the counter loads a new value, clears the prescaler if the timer holds it, and suppresses advancing for the next two instruction cycles. A watchdog clear empties the prescaler if the watchdog holds it. The counter rolls over from FFh to 00h and has no overflow flag.

Top module: `timer0_unit`

## Requirements
- R1: After reset the count is 00h, `wdt_tick` is low and the prescaler is empty. With the prescaler on the watchdog and `ratio_sel`=0, the first watchdog tick follows the second oscillator event.
- R2: With `src_ext`=0 and `pre_to_wdt`=1, the count advances once per instruction cycle. After a write of W followed by N≥2 fourth-quarter strobes, the count reads W+N-2 (mod 256).
- R3: With `src_ext`=1, the count advances on rising pin edges when `fall_edge`=0 and on falling pin edges when `fall_edge`=1. The pin is sampled on the second- and fourth-quarter strobes, and a level must be held for at least two quarters to be counted.
- R4: With `pre_to_wdt`=0, the timer advances once per 2^(`ratio_sel`+1) source events (code 0 gives 1:2, code 7 gives 1:256). With internal source, the count after a write of W and N≥1 fourth-quarter strobes is W+floor((N-1)/2^(sel+1)).
- R5: A write loads `tmr_wdata` at the next clock edge. It clears the prescaler when the timer holds it. The next two fourth-quarter strobes after the write do not advance the count.
- R6: With `pre_to_wdt`=1, `wdt_tick` pulses once per 2^(`ratio_sel`+1) oscillator events, and the timer gets its source events undivided.
- R7: With `pre_to_wdt`=0, `wdt_tick` pulses for one clock, one clock after each oscillator event.
- R8: `wdt_clr` empties the prescaler when the watchdog holds it. When the timer holds the prescaler, `wdt_clr` has no effect on the timer's division.
- R9: The count rolls over from FFh to 00h.
- R10: Without a write, the count changes only at a fourth-quarter strobe, and then by exactly +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| q2_stb | input | 1 | One-clock strobe, second quarter of an instruction cycle |
| q4_stb | input | 1 | One-clock strobe, fourth quarter (end of instruction cycle) |
| t0_pin | input | 1 | External count input, asynchronous |
| src_ext | input | 1 | 1: count pin edges, 0: count instruction cycles |
| fall_edge | input | 1 | 1: falling pin edges, 0: rising pin edges |
| pre_to_wdt | input | 1 | 1: prescaler serves watchdog, 0: prescaler serves timer |
| ratio_sel | input | 3 | Prescale code k, ratio 1:2^(k+1) |
| tmr_wr | input | 1 | Write strobe for the count |
| tmr_wdata | input | 8 | Value loaded by a write |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_osc_evt | input | 1 | One-clock event from the watchdog oscillator |
| tmr_val | output | 8 | Current count |
| wdt_tick | output | 1 | Prescaled or raw watchdog event |

## Verification
The internal source is tried with random start values, all eight ratio codes and both prescaler assignments. This separates an off-by-one in the write hold from an off-by-one in the divider, because their formulas differ in the constant term. Pin stimulus alternates levels from both idle levels under both edge selections, so counting the wrong polarity gives a different total. Watchdog runs split the oscillator events around a mid-run clear, chosen so that a clear which does not act, or acts on the wrong owner, changes the tick count. A start value just below FFh exposes wrong rollover.

// File: rtl/t0_pkg.sv
package t0_pkg;
    localparam int TMR_W    = 8;
    localparam int PRE_W    = 8;
    localparam int SEL_W    = 3;
    localparam int HOLD_CYC = 2;
    localparam int SYNC_N   = 2;

    typedef struct packed {
        logic             src_ext;
        logic             fall_edge;
        logic             pre_to_wdt;
        logic [SEL_W-1:0] sel;
    } t0_ctrl_t;

    typedef struct packed {
        logic tmr_evt;
        logic wdt_evt;
    } t0_pre_out_t;

    // low (sel+1) bits set: prescaler stage that produces a carry
    function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_W:0] t;
        t = ({{PRE_W{1'b0}}, 1'b1} << (32'(sel) + 1)) - 1'b1;
        return t[PRE_W-1:0];
    endfunction
endpackage

// File: rtl/t0_pin_sampler.sv
module t0_pin_sampler #(
    parameter int SYNC_STAGES = t0_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic q2_stb,
    input  logic q4_stb,
    input  logic pin,
    input  logic fall_edge,
    output logic edge_evt
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   smp;
    logic                   strobe;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign strobe = q2_stb | q4_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp      <= 1'b0;
            edge_evt <= 1'b0;
        end else if (strobe) begin
            smp      <= chain[SYNC_STAGES-1];
            edge_evt <= fall_edge ? (smp & ~chain[SYNC_STAGES-1])
                                  : (~smp & chain[SYNC_STAGES-1]);
        end else begin
            edge_evt <= 1'b0;
        end
    end

    // R3: a pin event only appears right after a sampling strobe
    assert_evt_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> !edge_evt);
endmodule

// File: rtl/t0_prescaler.sv
module t0_prescaler
    import t0_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          to_wdt,
    input  logic [SW-1:0] sel,
    input  logic          tmr_src_evt,
    input  logic          wdt_osc_evt,
    input  logic          tmr_wr,
    input  logic          wdt_clr,
    output t0_pre_out_t   pre_out
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] mask;
    logic          in_evt;
    logic          clr;
    logic          carry;
    logic          tick_q;

    assign mask   = PW'(tap_mask(SEL_W'(sel)));
    assign in_evt = to_wdt ? wdt_osc_evt : tmr_src_evt;
    assign clr    = to_wdt ? wdt_clr : tmr_wr;
    assign carry  = in_evt && ((cnt & mask) == mask) && !clr;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (in_evt) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= to_wdt ? carry : wdt_osc_evt;
    end

    assign pre_out.tmr_evt = to_wdt ? tmr_src_evt : carry;
    assign pre_out.wdt_evt = tick_q;

    // R1: prescaler leaves reset empty
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0 && !tick_q));
    // R8: a watchdog clear empties a watchdog-owned prescaler
    assert_wdt_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (to_wdt && wdt_clr) |=> (cnt == '0));
    // R5: a timer write empties a timer-owned prescaler
    assert_wr_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!to_wdt && tmr_wr) |=> (cnt == '0));
    // R7: unowned watchdog path passes events straight through
    assert_raw_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (!to_wdt && wdt_osc_evt) |=> pre_out.wdt_evt);
endmodule

// File: rtl/t0_count_core.sv
module t0_count_core #(
    parameter int TW   = t0_pkg::TMR_W,
    parameter int HOLD = t0_pkg::HOLD_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q4_stb,
    input  logic          tick_in,
    input  logic          wr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] tmr_q
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold;
    logic          pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
            pend  <= 1'b0;
            hold  <= '0;
        end else if (wr) begin
            tmr_q <= wdata;
            pend  <= 1'b0;
            hold  <= HW'(HOLD);
        end else if (q4_stb) begin
            pend <= tick_in;
            if (hold != '0)  hold  <= hold - 1'b1;
            else if (pend)   tmr_q <= tmr_q + 1'b1;
        end else if (tick_in) begin
            pend <= 1'b1;
        end
    end

    // R5: a write lands on the next edge
    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        wr |=> (tmr_q == $past(wdata)));
    // R5: phase-4 strobes inside the hold window do not advance
    assert_hold_window_R5: assert property (@(posedge clk) disable iff (rst)
        (hold != '0 && q4_stb && !wr) |=> $stable(tmr_q));
    // R10: no change away from phase 4
    assert_only_q4_R10: assert property (@(posedge clk) disable iff (rst)
        (!q4_stb && !wr) |=> $stable(tmr_q));
    // R10: phase 4 moves by at most one
    assert_step_one_R10: assert property (@(posedge clk) disable iff (rst)
        (q4_stb && !wr) |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + 1'b1));
    // R9: all-ones goes to zero when it advances
    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (q4_stb && !wr && tmr_q == {TW{1'b1}}) |=> (tmr_q == '0 || tmr_q == {TW{1'b1}}));
endmodule

// File: rtl/timer0_unit.sv
module timer0_unit
    import t0_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             q2_stb,
    input  logic             q4_stb,
    input  logic             t0_pin,
    input  logic             src_ext,
    input  logic             fall_edge,
    input  logic             pre_to_wdt,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             wdt_clr,
    input  logic             wdt_osc_evt,
    output logic [TMR_W-1:0] tmr_val,
    output logic             wdt_tick
);
    t0_ctrl_t    ctrl;
    t0_pre_out_t pre_out;
    logic        pin_evt;
    logic        src_evt;

    assign ctrl = '{src_ext: src_ext, fall_edge: fall_edge,
                    pre_to_wdt: pre_to_wdt, sel: ratio_sel};

    t0_pin_sampler #(.SYNC_STAGES(SYNC_N)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .q2_stb   (q2_stb),
        .q4_stb   (q4_stb),
        .pin      (t0_pin),
        .fall_edge(ctrl.fall_edge),
        .edge_evt (pin_evt)
    );

    assign src_evt = ctrl.src_ext ? pin_evt : q4_stb;

    t0_prescaler #(.PW(PRE_W), .SW(SEL_W)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .to_wdt     (ctrl.pre_to_wdt),
        .sel        (ctrl.sel),
        .tmr_src_evt(src_evt),
        .wdt_osc_evt(wdt_osc_evt),
        .tmr_wr     (tmr_wr),
        .wdt_clr    (wdt_clr),
        .pre_out    (pre_out)
    );

    t0_count_core #(.TW(TMR_W), .HOLD(HOLD_CYC)) u_core (
        .clk    (clk),
        .rst    (rst),
        .q4_stb (q4_stb),
        .tick_in(pre_out.tmr_evt),
        .wr     (tmr_wr),
        .wdata  (tmr_wdata),
        .tmr_q  (tmr_val)
    );

    assign wdt_tick = pre_out.wdt_evt;

    // R1: outputs quiet after reset
    assert_reset_out_R1: assert property (@(posedge clk)
        $past(rst) |-> (tmr_val == '0 && !wdt_tick));
endmodule

// File: tb/tb_timer0_unit.sv
module tb_timer0_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       q2_stb, q4_stb;
    logic       t0_pin = 1'b0, src_ext = 1'b0, fall_edge = 1'b0, pre_to_wdt = 1'b1;
    logic [2:0] ratio_sel = 3'd0;
    logic       tmr_wr = 1'b0, wdt_clr = 1'b0, wdt_osc_evt = 1'b0;
    logic [7:0] tmr_wdata = 8'd0;
    logic [7:0] tmr_val;
    logic       wdt_tick;

    logic [1:0] qcnt = 2'd0;
    int n_checks = 0, n_err = 0, tick_cnt = 0, viol = 0;
    logic       seen_q4 = 1'b0, seen_wr = 1'b0, seen_rst = 1'b1;
    logic [7:0] last_val = 8'd0;

    always #4 clk = ~clk;

    assign q2_stb = (qcnt == 2'd1);
    assign q4_stb = (qcnt == 2'd3);

    timer0_unit dut (
        .clk(clk), .rst(rst), .q2_stb(q2_stb), .q4_stb(q4_stb), .t0_pin(t0_pin),
        .src_ext(src_ext), .fall_edge(fall_edge), .pre_to_wdt(pre_to_wdt),
        .ratio_sel(ratio_sel), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
        .wdt_clr(wdt_clr), .wdt_osc_evt(wdt_osc_evt), .tmr_val(tmr_val),
        .wdt_tick(wdt_tick)
    );

    initial forever begin
        @(negedge clk);
        qcnt = qcnt + 2'd1;
    end

    // port monitor for R10 and tick counting
    always @(posedge clk) begin
        seen_q4  = q4_stb;
        seen_wr  = tmr_wr;
        seen_rst = rst;
    end
    always @(negedge clk) begin
        if (!seen_rst && wdt_tick) tick_cnt++;
        if (!seen_rst && !seen_wr && tmr_val != last_val)
            if (!seen_q4 || tmr_val != last_val + 8'd1) viol++;
        last_val = tmr_val;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_int(input int w, input bit to_wdt, input int k, input int n);
        int v;
        if (to_wdt) v = (n >= 2) ? w + n - 2 : w;
        else        v = w + (n - 1) / (2 << k);
        return v % 256;
    endfunction

    function automatic int exp_wdt(input bit to_wdt, input int k, input int n1,
                                   input bit clr_mid, input int n2);
        int m;
        m = 2 << k;
        if (!to_wdt)  return n1 + n2;
        if (clr_mid)  return n1 / m + n2 / m;
        return (n1 + n2) / m;
    endfunction

    task automatic wait_q4(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!q4_stb) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] w);
        tmr_wr = 1'b1; tmr_wdata = w;
        @(negedge clk);
        tmr_wr = 1'b0;
    endtask

    task automatic int_run(input string req, input int w, input bit to_wdt,
                           input int k, input int n);
        @(negedge clk);
        src_ext = 1'b0; pre_to_wdt = to_wdt; ratio_sel = 3'(k);
        do_write(8'(w));
        wait_q4(n);
        check(req, int'(tmr_val), exp_int(w, to_wdt, k, n));
    endtask

    task automatic ext_run(input string req, input bit fall, input bit to_wdt,
                           input int k, input bit start, input int ntog, input int w);
        int edges;
        int e;
        @(negedge clk);
        src_ext = 1'b1; fall_edge = fall; pre_to_wdt = to_wdt; ratio_sel = 3'(k);
        t0_pin = start;
        repeat (12) @(negedge clk);
        do_write(8'(w));
        repeat (12) @(negedge clk);
        edges = 0;
        for (int i = 0; i < ntog; i++) begin
            t0_pin = ~t0_pin;
            if (t0_pin != fall) edges++;
            repeat (6) @(negedge clk);
        end
        repeat (16) @(negedge clk);
        e = to_wdt ? edges : edges / (2 << k);
        check(req, int'(tmr_val), (w + e) % 256);
        src_ext = 1'b0;
    endtask

    task automatic osc_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            wdt_osc_evt = 1'b1; @(negedge clk);
            wdt_osc_evt = 1'b0; @(negedge clk); @(negedge clk);
        end
    endtask

    task automatic pulse_clr;
        wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
    endtask

    task automatic wdt_run(input string req, input bit to_wdt, input int k,
                           input int n1, input bit clr_mid, input int n2);
        int base;
        @(negedge clk);
        src_ext = 1'b0; pre_to_wdt = to_wdt; ratio_sel = 3'(k);
        @(negedge clk);
        pulse_clr();
        repeat (2) @(negedge clk);
        base = tick_cnt;
        osc_pulses(n1);
        if (clr_mid) pulse_clr();
        osc_pulses(n2);
        repeat (4) @(negedge clk);
        check(req, tick_cnt - base, exp_wdt(to_wdt, k, n1, clr_mid, n2));
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int base;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 count", int'(tmr_val), 0);
        check("R1 tick", int'(wdt_tick), 0);
        // R1: empty prescaler, 1:2 on watchdog -> tick on the 2nd event only
        base = tick_cnt;
        osc_pulses(1);
        check("R1 first event", tick_cnt - base, 0);
        osc_pulses(1);
        check("R1 second event", tick_cnt - base, 1);

        // R2: one step per instruction cycle
        int_run("R2", 8'h10, 1'b1, 5, 10);
        // R5: hold window after a write
        int_run("R5 n1", 8'h40, 1'b1, 0, 1);
        int_run("R5 n2", 8'h40, 1'b1, 0, 2);
        int_run("R5 n3", 8'h40, 1'b1, 0, 3);
        // R4: ratio extremes
        int_run("R4 1:2", 0, 1'b0, 0, 9);
        int_run("R4 1:256", 0, 1'b0, 7, 300);
        int_run("R4 1:8", 8'h20, 1'b0, 2, 41);
        // R9: rollover
        int_run("R9", 8'hFE, 1'b1, 0, 5);
        int_run("R9 prescaled", 8'hFF, 1'b0, 0, 3);
        // R3: edge selection, both idle levels
        ext_run("R3 rise", 1'b0, 1'b1, 0, 1'b0, 9, 5);
        ext_run("R3 fall", 1'b1, 1'b1, 0, 1'b0, 9, 5);
        ext_run("R3 rise idle-high", 1'b0, 1'b1, 0, 1'b1, 6, 8'hFD);
        ext_run("R4 ext 1:4", 1'b0, 1'b0, 1, 1'b0, 20, 0);
        // R6 / R7 / R8 watchdog path
        wdt_run("R6 1:4", 1'b1, 1, 13, 1'b0, 0);
        wdt_run("R7 raw", 1'b0, 3, 7, 1'b0, 0);
        wdt_run("R8 clr owned", 1'b1, 1, 3, 1'b1, 2);
        wdt_run("R7 clr unowned", 1'b0, 1, 3, 1'b1, 2);
        // R8: watchdog clear leaves a timer-owned prescaler alone
        @(negedge clk);
        src_ext = 1'b0; pre_to_wdt = 1'b0; ratio_sel = 3'd2;
        do_write(8'd0);
        wait_q4(5);
        pulse_clr();
        wait_q4(12);
        check("R8 timer-owned", int'(tmr_val), 2);

        // random mix: R2 R4 R5 R9 internal source
        for (int i = 0; i < 30; i++) begin
            int w, k, n;
            bit p;
            w = int'($urandom % 256);
            k = int'($urandom % 8);
            n = 1 + int'($urandom % 300);
            p = 1'($urandom % 2);
            int_run(p ? "R2 random" : "R4 random", w, p, k, n);
        end
        for (int i = 0; i < 6; i++) begin
            ext_run("R3 random", 1'($urandom % 2), 1'($urandom % 2),
                    int'($urandom % 2), 1'($urandom % 2), 4 + int'($urandom % 12),
                    int'($urandom % 256));
        end
        for (int i = 0; i < 6; i++) begin
            wdt_run("R6 random", 1'b1, int'($urandom % 3), int'($urandom % 20),
                    1'($urandom % 2), int'($urandom % 20));
        end

        check("R10 step only on phase 4", viol, 0);
        finish_run();
    end
endmodule